// File: doc/BRIEF.md
# Active Cycle Counter with Validity Flag

This block measures how long transfer recording has been active between two recorded control transfers. It counts every clock cycle in which its `active_i` input is high; upstream logic drives that input high only when the current privilege mode is enabled for recording and recording is not frozen. A record-writing unit reads `cnt_o` and `vld_o` in the cycle it raises `xfer_i` and stores both in the new record's metadata. At the next edge the counter starts again from zero and the flag is set.

The flag tells whether the interval was fully counted. Three kinds of event drop it:
- a write to the recording control register (`ctl_wr_i`);
- a clear command (`clear_i`), which also zeroes the count;
- an implementation-specific strobe (`inval_i`) that reports active cycles the counter missed.

When the count reaches its maximum it saturates and does not wrap. Record storage and transfer filtering belong to other blocks.

Top module: `actcyc_counter`

## Requirements
- R1: A synchronous active-high reset gives `cnt_o`=0 and `vld_o`=0 at the first edge at which it is sampled high.
- R2: With no transfer, control write or clear, `cnt_o` rises by exactly one at each edge at which `active_i` is high, and holds when `active_i` is low.
- R3: `cnt_o` saturates at all-ones (2^CNT_W-1): further active cycles leave it at that value.
- R4: A control write (`ctl_wr_i`=1) makes `cnt_o`=0 and `vld_o`=0 one cycle later, whatever the other inputs are.
- R5: A clear command (`clear_i`=1) makes `cnt_o`=0 and `vld_o`=0 one cycle later, whatever the other inputs are.
- R6: The values for a record are the `cnt_o`/`vld_o` seen in the `xfer_i` cycle. One cycle later `cnt_o`=0, and `vld_o`=1 unless `inval_i` was also high.
- R7: When a control write or clear coincides with `xfer_i`, the reset wins: the next cycle shows `cnt_o`=0 and `vld_o`=0.
- R8: `inval_i` clears `vld_o` one cycle later and leaves the counting of `cnt_o` unaffected.
- R9: The first record after a clear or control write carries `vld_o`=0, however long recording was active before the transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| active_i | input | 1 | Recording is active this cycle (mode enabled, not frozen) |
| xfer_i | input | 1 | Qualified transfer is being recorded this cycle |
| ctl_wr_i | input | 1 | Write to the recording control register |
| clear_i | input | 1 | Clear command for the record buffer and counter |
| inval_i | input | 1 | Active cycles were missed; the interval is not valid |
| cnt_o | output | CNT_W | Active cycles counted since the last restart |
| vld_o | output | 1 | The count covers a fully counted interval |

## Verification
Each input acts at the next rising edge, so each result on `cnt_o` and `vld_o` is due one cycle after its stimulus. The record values are the outputs present in the transfer cycle itself. The bench drives inputs at the falling edge and compares the outputs at the following falling edge with an arithmetic model updated from the same inputs. A sweep applies all 32 input combinations from empty, mid-range and saturated counts, with the flag both high and low. A pseudo-random run and directed sequences for the reset, priority and first-record cases follow the sweep.

// File: rtl/actcyc_pkg.sv
package actcyc_pkg;

  typedef enum logic [1:0] {
    CNT_HOLD    = 2'd0,
    CNT_STEP    = 2'd1,
    CNT_RESTART = 2'd2,
    CNT_ZERO    = 2'd3
  } cnt_op_e;

  typedef enum logic [1:0] {
    FLG_KEEP = 2'd0,
    FLG_SET  = 2'd1,
    FLG_DROP = 2'd2
  } flg_op_e;

endpackage

// File: rtl/actcyc_evt_decode.sv
module actcyc_evt_decode
  import actcyc_pkg::*;
(
  input  logic    active_i,
  input  logic    xfer_i,
  input  logic    ctl_wr_i,
  input  logic    clear_i,
  input  logic    inval_i,
  output cnt_op_e cnt_op_o,
  output flg_op_e flg_op_o
);

  logic zero_evt;

  assign zero_evt = ctl_wr_i | clear_i;

  // Priority: control write / clear, then transfer, then plain counting.
  always_comb begin
    if (zero_evt)      cnt_op_o = CNT_ZERO;
    else if (xfer_i)   cnt_op_o = CNT_RESTART;
    else if (active_i) cnt_op_o = CNT_STEP;
    else               cnt_op_o = CNT_HOLD;
  end

  // A missed-cycle report overrides the set caused by a transfer.
  always_comb begin
    if (zero_evt || inval_i) flg_op_o = FLG_DROP;
    else if (xfer_i)         flg_op_o = FLG_SET;
    else                     flg_op_o = FLG_KEEP;
  end

endmodule

// File: rtl/actcyc_sat_count.sv
module actcyc_sat_count
  import actcyc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  cnt_op_e          op_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic at_max;

  assign at_max = (cnt_o == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
    end else begin
      case (op_i)
        CNT_ZERO, CNT_RESTART: cnt_o <= '0;
        CNT_STEP:              if (!at_max) cnt_o <= cnt_o + 1'b1;
        default:               cnt_o <= cnt_o;
      endcase
    end
  end

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (op_i == CNT_STEP && !at_max) |=> (cnt_o == $past(cnt_o) + 1'b1)); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (op_i == CNT_HOLD) |=> $stable(cnt_o)); // R2

  AST_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (op_i == CNT_STEP && at_max) |=> (cnt_o == CNT_MAX)); // R3

endmodule

// File: rtl/actcyc_valid_flag.sv
module actcyc_valid_flag
  import actcyc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  flg_op_e op_i,
  output logic    vld_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
    end else begin
      case (op_i)
        FLG_SET:  vld_o <= 1'b1;
        FLG_DROP: vld_o <= 1'b0;
        default:  vld_o <= vld_o;
      endcase
    end
  end

  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (rst)
    (op_i == FLG_KEEP) |=> $stable(vld_o)); // R8

endmodule

// File: rtl/actcyc_counter.sv
module actcyc_counter
  import actcyc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active_i,
  input  logic             xfer_i,
  input  logic             ctl_wr_i,
  input  logic             clear_i,
  input  logic             inval_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             vld_o
);

  cnt_op_e cnt_op;
  flg_op_e flg_op;

  actcyc_evt_decode u_dec (
    .active_i (active_i),
    .xfer_i   (xfer_i),
    .ctl_wr_i (ctl_wr_i),
    .clear_i  (clear_i),
    .inval_i  (inval_i),
    .cnt_op_o (cnt_op),
    .flg_op_o (flg_op)
  );

  actcyc_sat_count #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .op_i  (cnt_op),
    .cnt_o (cnt_o)
  );

  actcyc_valid_flag u_flg (
    .clk   (clk),
    .rst   (rst),
    .op_i  (flg_op),
    .vld_o (vld_o)
  );

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (cnt_o == '0 && !vld_o)); // R1

  AST_CTL_WRITE_ZERO: assert property (@(posedge clk) disable iff (rst)
    ctl_wr_i |=> (cnt_o == '0 && !vld_o)); // R4

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (cnt_o == '0 && !vld_o)); // R5

  AST_XFER_RESTART: assert property (@(posedge clk) disable iff (rst)
    (xfer_i && !ctl_wr_i && !clear_i) |=> (cnt_o == '0)); // R6

  AST_XFER_VALID: assert property (@(posedge clk) disable iff (rst)
    (xfer_i && !ctl_wr_i && !clear_i && !inval_i) |=> vld_o); // R6

  AST_RESET_BEATS_XFER: assert property (@(posedge clk) disable iff (rst)
    (xfer_i && (ctl_wr_i || clear_i)) |=> !vld_o); // R7

  AST_INVAL_DROP: assert property (@(posedge clk) disable iff (rst)
    inval_i |=> !vld_o); // R8

  AST_INVAL_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
    (inval_i && !active_i && !xfer_i && !ctl_wr_i && !clear_i)
      |=> (cnt_o == $past(cnt_o))); // R8

endmodule

// File: tb/sim_actcyc_counter.sv
module sim_actcyc_counter;

  localparam int W   = 4;
  localparam int MAX = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         active_i = 1'b0, xfer_i = 1'b0, ctl_wr_i = 1'b0;
  logic         clear_i = 1'b0, inval_i = 1'b0;
  logic [W-1:0] cnt_o;
  logic         vld_o;

  int checks = 0;
  int failures = 0;
  int m_cnt = 0;
  int m_vld = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  actcyc_counter #(.CNT_W(W)) u0 (
    .clk(clk), .rst(rst), .active_i(active_i), .xfer_i(xfer_i),
    .ctl_wr_i(ctl_wr_i), .clear_i(clear_i), .inval_i(inval_i),
    .cnt_o(cnt_o), .vld_o(vld_o)
  );

  task automatic chk(input string tag, input int ec, input int ev);
    checks++;
    if (int'(cnt_o) != ec || int'(vld_o) != ev) begin
      failures++;
      $display("FAIL %s cnt=%0d vld=%0d expected cnt=%0d vld=%0d",
               tag, cnt_o, vld_o, ec, ev);
    end
  endtask

  // One cycle from a falling edge to the next; the model follows the requirements.
  task automatic cyc(input bit a, input bit x, input bit w, input bit c,
                     input bit i, input bit do_chk);
    string tag;
    if (w && x)      tag = "R7";
    else if (c && x) tag = "R7";
    else if (w)      tag = "R4";
    else if (c)      tag = "R5";
    else if (x)      tag = "R6";
    else if (i)      tag = "R8";
    else if (a && m_cnt == MAX) tag = "R3";
    else             tag = "R2";
    active_i = a; xfer_i = x; ctl_wr_i = w; clear_i = c; inval_i = i;
    if (w || c) begin
      m_cnt = 0; m_vld = 0;
    end else if (x) begin
      m_cnt = 0; m_vld = i ? 0 : 1;
    end else begin
      if (a && m_cnt < MAX) m_cnt = m_cnt + 1;
      if (i) m_vld = 0;
    end
    @(posedge clk);
    @(negedge clk);
    if (do_chk) chk(tag, m_cnt, m_vld);
  endtask

  task automatic setup_state(input int n, input bit v);
    cyc(0, 0, 0, 1, 0, 0);
    if (v) cyc(0, 1, 0, 0, 0, 0);
    for (int k = 0; k < n; k++) cyc(1, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit [15:0] lfsr;
    @(negedge clk);
    @(negedge clk);
    chk("R1", 0, 0);
    rst = 1'b0;

    // R2: counting and holding
    for (int k = 0; k < 5; k++) cyc(1, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 1);
    // R3: saturation
    for (int k = 0; k < MAX + 3; k++) cyc(1, 0, 0, 0, 0, 1);

    // Sweep every input combination from several starting states
    for (int s = 0; s < 6; s++) begin
      for (int combo = 0; combo < 32; combo++) begin
        int n;
        n = (s % 3 == 0) ? 0 : ((s % 3 == 1) ? 7 : MAX + 2);
        setup_state(n, s >= 3);
        cyc(combo[0], combo[1], combo[2], combo[3], combo[4], 1);
      end
    end

    // R9: first record after a clear carries an invalid flag
    cyc(0, 1, 0, 0, 0, 1);
    cyc(0, 0, 0, 1, 0, 1);
    for (int k = 0; k < 9; k++) cyc(1, 0, 0, 0, 0, 0);
    checks++;
    if (vld_o !== 1'b0 || int'(cnt_o) != 9) begin
      failures++;
      $display("FAIL R9 cnt=%0d vld=%0d expected cnt=9 vld=0", cnt_o, vld_o);
    end
    cyc(1, 1, 0, 0, 0, 1);
    // R9 after a control write as well
    cyc(1, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0, 1);
    for (int k = 0; k < 3; k++) cyc(1, 0, 0, 0, 0, 0);
    checks++;
    if (vld_o !== 1'b0) begin
      failures++;
      $display("FAIL R9 vld=%0d expected vld=0", vld_o);
    end

    // Pseudo-random run
    lfsr = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[0] | lfsr[5], lfsr[1] & lfsr[2] & lfsr[7],
          lfsr[3] & lfsr[4] & lfsr[8] & lfsr[9],
          lfsr[6] & lfsr[11] & lfsr[12] & lfsr[13],
          lfsr[14] & lfsr[15] & lfsr[2], 1);
    end

    // R1: reset mid-run
    cyc(1, 1, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1", 0, 0);
    rst = 1'b0;
    m_cnt = 0; m_vld = 0;
    cyc(1, 0, 0, 0, 0, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule